// File: doc/BRIEF.md
# Multi-Bank Selectable Clock Divider

This block derives three banks of divided clocks from one common source clock. Two reference clocks and one fast clock enter the block. A reference pick input chooses one of the two references. A source-mode input then selects either that reference or the fast clock as the source for every divider. Each bank has its own ratio select, and each bank decodes its select through a ratio table of its own. Every ratio is even, so each divider toggles its output after half the ratio in source edges, which gives a 50% duty cycle.

Bank A and bank B each drive four output pairs, and the feedback bank drives two. Each pair has a true line and a complement line, and all pairs of one bank carry the same clock. An active-high master reset clears every divider at once and forces each pair to a defined state. After the reset is released, all banks count from the same source edge. A change to a bank's select takes effect only at the start of that bank's next period, so no runt pulses are produced. The source multiplexing is modelled behaviourally. The fast clock is an ordinary input.

Top module: `bank_clock_divider`

## Requirements
- R1: Bank A decodes `sel_a` as 0→÷2, 1→÷4, 2→÷6, 3→÷8. The `a_p` period is that many source-clock cycles.
- R2: Bank B decodes `sel_b` as 0→÷2, 1→÷4, 2→÷8, 3→÷12. The `b_p` period is that many source-clock cycles.
- R3: The feedback bank decodes `sel_fb` as 0→÷4, 1→÷6, 2→÷8, 3→÷10, 4→÷8, 5→÷12, 6→÷16, 7→÷20. Codes 2 and 4 give the same ratio. No output phase of this bank is shorter than two source cycles.
- R4: While `master_rst` is 1, every true output is 0 and every complement output is 1, even with the source clock running. The outputs take this state as soon as the reset is asserted.
- R5: Each complement output is the inverse of its true output, and all pairs within one bank carry identical values.
- R6: For a ratio N, the high phase of each output lasts N/2 source cycles and the full period lasts N cycles (50% duty cycle).
- R7: When `use_fast` is 0, the chosen reference clock is the divider source. When it is 1, `fast_in` is the source.
- R8: When `ref_pick` is 0, `ref_in0` is the chosen reference. When it is 1, `ref_in1` is chosen.
- R9: After `master_rst` falls, the first rising edge of each bank comes on its (N/2)-th source rising edge. Banks with equal ratios therefore rise on the same edge.
- R10: A bank samples its select only at the source edge that starts a new period (the terminal count of the low phase) and at the first edge after reset. A period that is already running keeps its old ratio, and the next period uses the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_in0 | input | 1 | Reference clock, chosen when `ref_pick` is 0 |
| ref_in1 | input | 1 | Reference clock, chosen when `ref_pick` is 1 |
| fast_in | input | 1 | Fast clock, used as the source when `use_fast` is 1 |
| ref_pick | input | 1 | Reference pick: 0 selects `ref_in0`, 1 selects `ref_in1` |
| use_fast | input | 1 | Source mode: 0 uses the chosen reference, 1 uses `fast_in` |
| master_rst | input | 1 | Active-high master reset for all dividers |
| sel_a | input | 2 | Bank A ratio select |
| sel_b | input | 2 | Bank B ratio select |
| sel_fb | input | 3 | Feedback bank ratio select |
| a_p | output | 4 | Bank A true outputs |
| a_n | output | 4 | Bank A complement outputs |
| b_p | output | 4 | Bank B true outputs |
| b_n | output | 4 | Bank B complement outputs |
| fb_p | output | 2 | Feedback bank true outputs |
| fb_n | output | 2 | Feedback bank complement outputs |

## Verification
A corrupted half-count entry or a wrong counter compare shows up as a wrong period or a wrong high time on the affected bank's outputs. It appears within one output period, which is at most 20 source cycles. A divider stuck in one phase shows within 11 cycles as a phase that outlasts the bank's largest half-ratio. A select register that loads at the wrong moment moves the next rising edge by some number of source cycles, so the edge timing reveals it within two periods of the select change. A reset that does not reach every pair shows at once as a true output that is not 0.

// File: rtl/vdiv_pkg.sv
package vdiv_pkg;

   typedef enum logic [1:0] {BK_A = 2'd0, BK_B = 2'd1, BK_FB = 2'd2} bank_kind_e;

   localparam int SEL_W_AB = 2;
   localparam int SEL_W_FB = 3;

   // half of the divide ratio for one select code of one bank
   function automatic int half_div(bank_kind_e k, int code);
      int h;
      h = 1;
      case (k)
         BK_A: h = code + 1;
         BK_B: begin
            case (code)
               0:       h = 1;
               1:       h = 2;
               2:       h = 4;
               default: h = 6;
            endcase
         end
         default: begin
            case (code)
               0:       h = 2;
               1:       h = 3;
               2:       h = 4;
               3:       h = 5;
               4:       h = 4;
               5:       h = 6;
               6:       h = 8;
               default: h = 10;
            endcase
         end
      endcase
      return h;
   endfunction

   function automatic int max_half(bank_kind_e k, int sel_w);
      int m;
      m = 0;
      for (int c = 0; c < (1 << sel_w); c++)
         if (half_div(k, c) > m) m = half_div(k, c);
      return m;
   endfunction

endpackage

// File: rtl/clk_source_pick.sv
module clk_source_pick (
   input  logic ref_in0,
   input  logic ref_in1,
   input  logic fast_in,
   input  logic ref_pick,
   input  logic use_fast,
   output logic src_clk
);
   logic ref_sel;

   always_comb begin
      ref_sel = ref_pick ? ref_in1 : ref_in0;
      src_clk = use_fast ? fast_in : ref_sel;
   end
endmodule

// File: rtl/ratio_divider.sv
module ratio_divider #(
   parameter vdiv_pkg::bank_kind_e KIND = vdiv_pkg::BK_A,
   parameter int SEL_W   = 2,
   parameter int NUM_OUT = 4
) (
   input  logic               src_clk,
   input  logic               rst,
   input  logic [SEL_W-1:0]   sel,
   output logic [NUM_OUT-1:0] true_o,
   output logic [NUM_OUT-1:0] comp_o
);
   localparam int EXP_W = (KIND == vdiv_pkg::BK_FB) ? vdiv_pkg::SEL_W_FB : vdiv_pkg::SEL_W_AB;
   localparam int CODES = 1 << SEL_W;
   localparam int MAX_H = vdiv_pkg::max_half(KIND, SEL_W);
   localparam int CNT_W = $clog2(MAX_H + 1);

   if (SEL_W != EXP_W) begin : g_bad_sel_w
      $error("ratio_divider: SEL_W does not match the bank kind");
   end
   if (NUM_OUT < 1) begin : g_bad_num
      $error("ratio_divider: NUM_OUT must be at least 1");
   end

   // half-count table, one entry per select code
   logic [CNT_W-1:0] half_tab [CODES];
   for (genvar g = 0; g < CODES; g++) begin : g_tab
      assign half_tab[g] = CNT_W'(vdiv_pkg::half_div(KIND, g));
   end

   logic [CNT_W-1:0] cnt;
   logic [SEL_W-1:0] cur_sel;
   logic [SEL_W-1:0] eff_sel;
   logic             pending;
   logic             q;
   logic [CNT_W-1:0] last;

   always_comb begin
      eff_sel = pending ? sel : cur_sel;
      last    = half_tab[eff_sel] - CNT_W'(1);
   end

   always_ff @(posedge src_clk or posedge rst) begin
      if (rst) begin
         cnt     <= '0;
         q       <= 1'b0;
         cur_sel <= '0;
         pending <= 1'b1;
      end else begin
         pending <= 1'b0;
         if (cnt == last) begin
            cnt <= '0;
            q   <= ~q;
            if (!q) cur_sel <= sel;   // period boundary: low phase ends
         end else begin
            cnt <= cnt + CNT_W'(1);
            if (pending) cur_sel <= sel;
         end
      end
   end

   for (genvar p = 0; p < NUM_OUT; p++) begin : g_pair
      assign true_o[p] = q;
      assign comp_o[p] = ~q;
   end
endmodule

// File: rtl/bank_clock_divider.sv
module bank_clock_divider #(
   parameter int NUM_A  = 4,
   parameter int NUM_B  = 4,
   parameter int NUM_FB = 2
) (
   input  logic                          ref_in0,
   input  logic                          ref_in1,
   input  logic                          fast_in,
   input  logic                          ref_pick,
   input  logic                          use_fast,
   input  logic                          master_rst,
   input  logic [vdiv_pkg::SEL_W_AB-1:0] sel_a,
   input  logic [vdiv_pkg::SEL_W_AB-1:0] sel_b,
   input  logic [vdiv_pkg::SEL_W_FB-1:0] sel_fb,
   output logic [NUM_A-1:0]              a_p,
   output logic [NUM_A-1:0]              a_n,
   output logic [NUM_B-1:0]              b_p,
   output logic [NUM_B-1:0]              b_n,
   output logic [NUM_FB-1:0]             fb_p,
   output logic [NUM_FB-1:0]             fb_n
);
   logic src_clk;

   clk_source_pick u_src (
      .ref_in0 (ref_in0),
      .ref_in1 (ref_in1),
      .fast_in (fast_in),
      .ref_pick(ref_pick),
      .use_fast(use_fast),
      .src_clk (src_clk)
   );

   ratio_divider #(.KIND(vdiv_pkg::BK_A), .SEL_W(vdiv_pkg::SEL_W_AB), .NUM_OUT(NUM_A)) u_bank_a (
      .src_clk(src_clk), .rst(master_rst), .sel(sel_a), .true_o(a_p), .comp_o(a_n)
   );

   ratio_divider #(.KIND(vdiv_pkg::BK_B), .SEL_W(vdiv_pkg::SEL_W_AB), .NUM_OUT(NUM_B)) u_bank_b (
      .src_clk(src_clk), .rst(master_rst), .sel(sel_b), .true_o(b_p), .comp_o(b_n)
   );

   ratio_divider #(.KIND(vdiv_pkg::BK_FB), .SEL_W(vdiv_pkg::SEL_W_FB), .NUM_OUT(NUM_FB)) u_bank_fb (
      .src_clk(src_clk), .rst(master_rst), .sel(sel_fb), .true_o(fb_p), .comp_o(fb_n)
   );
endmodule

// File: rtl/bank_clock_divider_chk.sv
module bank_clock_divider_chk #(
   parameter int NUM_A  = 4,
   parameter int NUM_B  = 4,
   parameter int NUM_FB = 2
) (
   input logic              src_clk,
   input logic              master_rst,
   input logic [NUM_A-1:0]  a_p,
   input logic [NUM_A-1:0]  a_n,
   input logic [NUM_B-1:0]  b_p,
   input logic [NUM_B-1:0]  b_n,
   input logic [NUM_FB-1:0] fb_p,
   input logic [NUM_FB-1:0] fb_n
);
   localparam int MAX_A  = vdiv_pkg::max_half(vdiv_pkg::BK_A,  vdiv_pkg::SEL_W_AB);
   localparam int MAX_B  = vdiv_pkg::max_half(vdiv_pkg::BK_B,  vdiv_pkg::SEL_W_AB);
   localparam int MAX_FB = vdiv_pkg::max_half(vdiv_pkg::BK_FB, vdiv_pkg::SEL_W_FB);

   logic       prev_a, prev_b, prev_fb;
   logic [7:0] run_a, run_b, run_fb;

   // length of the current output phase, in source edges
   always_ff @(posedge src_clk or posedge master_rst) begin
      if (master_rst) begin
         prev_a <= 1'b0; prev_b <= 1'b0; prev_fb <= 1'b0;
         run_a  <= '0;   run_b  <= '0;   run_fb  <= '0;
      end else begin
         prev_a  <= a_p[0];
         prev_b  <= b_p[0];
         prev_fb <= fb_p[0];
         run_a   <= (a_p[0]  != prev_a)  ? 8'd1 : run_a  + 8'd1;
         run_b   <= (b_p[0]  != prev_b)  ? 8'd1 : run_b  + 8'd1;
         run_fb  <= (fb_p[0] != prev_fb) ? 8'd1 : run_fb + 8'd1;
      end
   end

   p_a_max_phase_r1: assert property (@(posedge src_clk) disable iff (master_rst)
      run_a <= 8'(MAX_A));

   p_b_max_phase_r2: assert property (@(posedge src_clk) disable iff (master_rst)
      run_b <= 8'(MAX_B));

   p_fb_max_phase_r3: assert property (@(posedge src_clk) disable iff (master_rst)
      run_fb <= 8'(MAX_FB));

   p_fb_min_phase_r3: assert property (@(posedge src_clk) disable iff (master_rst)
      ($rose(fb_p[0]) || $fell(fb_p[0])) |=> $stable(fb_p[0]));

   // the reset state itself is the subject here, so reset does not disable it
   p_reset_state_r4: assert property (@(negedge src_clk)
      master_rst |-> (a_p == '0 && b_p == '0 && fb_p == '0 &&
                      a_n == '1 && b_n == '1 && fb_n == '1));
endmodule

bind bank_clock_divider bank_clock_divider_chk #(.NUM_A(NUM_A), .NUM_B(NUM_B), .NUM_FB(NUM_FB)) u_chk (
   .src_clk(src_clk), .master_rst(master_rst),
   .a_p(a_p), .a_n(a_n), .b_p(b_p), .b_n(b_n), .fb_p(fb_p), .fb_n(fb_n)
);

// File: tb/sim_bank_clock_divider.sv
`timescale 1ns/1ps
module sim_bank_clock_divider;
   logic       ref_in0, ref_in1, fast_in;
   logic       ref_pick, use_fast, master_rst;
   logic [1:0] sel_a, sel_b;
   logic [2:0] sel_fb;
   logic [3:0] a_p, a_n, b_p, b_n;
   logic [1:0] fb_p, fb_n;

   int total = 0;
   int bad   = 0;

   bank_clock_divider u0 (
      .ref_in0(ref_in0), .ref_in1(ref_in1), .fast_in(fast_in),
      .ref_pick(ref_pick), .use_fast(use_fast), .master_rst(master_rst),
      .sel_a(sel_a), .sel_b(sel_b), .sel_fb(sel_fb),
      .a_p(a_p), .a_n(a_n), .b_p(b_p), .b_n(b_n), .fb_p(fb_p), .fb_n(fb_n)
   );

   // 50 MHz fast clock, references at 30 ns and 70 ns
   initial begin fast_in = 1'b0; forever #10 fast_in = ~fast_in; end
   initial begin ref_in0 = 1'b0; forever #15 ref_in0 = ~ref_in0; end
   initial begin ref_in1 = 1'b0; forever #35 ref_in1 = ~ref_in1; end

   // {bank[1:0], code[2:0], ratio[4:0]}; bank 0=A, 1=B, 2=feedback
   localparam logic [9:0] VEC [16] = '{
      {2'd0, 3'd0, 5'd2},  {2'd0, 3'd1, 5'd4},  {2'd0, 3'd2, 5'd6},  {2'd0, 3'd3, 5'd8},
      {2'd1, 3'd0, 5'd2},  {2'd1, 3'd1, 5'd4},  {2'd1, 3'd2, 5'd8},  {2'd1, 3'd3, 5'd12},
      {2'd2, 3'd0, 5'd4},  {2'd2, 3'd1, 5'd6},  {2'd2, 3'd2, 5'd8},  {2'd2, 3'd3, 5'd10},
      {2'd2, 3'd4, 5'd8},  {2'd2, 3'd5, 5'd12}, {2'd2, 3'd6, 5'd16}, {2'd2, 3'd7, 5'd20}
   };

   task automatic check(input string req, input int got, input int exp);
      total++;
      if (got != exp) begin
         bad++;
         $display("FAIL %s got=%0d exp=%0d", req, got, exp);
      end
   endtask

   task automatic wait_rise(input int w);
      case (w)
         0:       @(posedge a_p[0]);
         1:       @(posedge b_p[0]);
         default: @(posedge fb_p[0]);
      endcase
   endtask

   task automatic wait_fall(input int w);
      case (w)
         0:       @(negedge a_p[0]);
         1:       @(negedge b_p[0]);
         default: @(negedge fb_p[0]);
      endcase
   endtask

   task automatic check_reset_state(input string tag);
      check({tag, " R4 true low"},  int'({a_p, b_p, fb_p}), 0);
      check({tag, " R4 comp high"}, int'({a_n, b_n, fb_n}), 1023);
   endtask

   task automatic check_pairs();
      check("R5 inverse", int'({a_n, b_n, fb_n} == ~{a_p, b_p, fb_p}), 1);
      check("R5 uniform", int'((a_p == 4'h0 || a_p == 4'hF) && (b_p == 4'h0 || b_p == 4'hF) &&
                               (fb_p == 2'h0 || fb_p == 2'h3)), 1);
   endtask

   initial begin
      #2_000_000;
      bad++;
      $display("FAIL watchdog got=timeout exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int t1, th, t2, t3;
      int fa, fbb, ff;
      master_rst = 1'b1; use_fast = 1'b1; ref_pick = 1'b0;
      sel_a = '0; sel_b = '0; sel_fb = '0;

      // R4: reset state with the source clock running
      repeat (3) @(negedge fast_in);
      check_reset_state("initial");

      // table walk: R1, R2, R3 periods and R6 duty on the fast clock
      foreach (VEC[i]) begin
         int bank, code, ratio;
         string rq;
         bank  = int'(VEC[i][9:8]);
         code  = int'(VEC[i][7:5]);
         ratio = int'(VEC[i][4:0]);
         rq    = (bank == 0) ? "R1" : (bank == 1) ? "R2" : "R3";
         master_rst = 1'b1;
         @(negedge fast_in);
         sel_a  = (bank == 0) ? 2'(code) : 2'd0;
         sel_b  = (bank == 1) ? 2'(code) : 2'd0;
         sel_fb = (bank == 2) ? 3'(code) : 3'd0;
         @(negedge fast_in);
         master_rst = 1'b0;
         wait_rise(bank); t1 = int'($time);
         wait_fall(bank); th = int'($time);
         wait_rise(bank); t2 = int'($time);
         check(rq, t2 - t1, ratio * 20);
         check("R6", th - t1, ratio * 10);
         @(negedge fast_in);
         check_pairs();
      end

      // R7 / R8: reference sources
      master_rst = 1'b1; use_fast = 1'b0; ref_pick = 1'b0;
      sel_a = 2'd1; sel_b = 2'd0; sel_fb = 3'd0;
      @(negedge fast_in); #3 master_rst = 1'b0;
      wait_rise(0); t1 = int'($time); wait_rise(0); t2 = int'($time);
      check("R7 R8 ref_in0 period", t2 - t1, 4 * 30);
      master_rst = 1'b1; ref_pick = 1'b1;
      @(negedge fast_in); #3 master_rst = 1'b0;
      wait_rise(0); t1 = int'($time); wait_rise(0); t2 = int'($time);
      check("R8 ref_in1 period", t2 - t1, 4 * 70);
      master_rst = 1'b1; use_fast = 1'b1; ref_pick = 1'b0;
      @(negedge fast_in); master_rst = 1'b0;
      wait_rise(0); t1 = int'($time); wait_rise(0); t2 = int'($time);
      check("R7 fast period", t2 - t1, 4 * 20);

      // R9: first rising edge per bank after reset release
      master_rst = 1'b1;
      @(negedge fast_in);
      sel_a = 2'd3; sel_b = 2'd2; sel_fb = 3'd2;     // all divide by 8
      @(negedge fast_in);
      master_rst = 1'b0;
      fa = -1; fbb = -1; ff = -1;
      for (int k = 1; k <= 12; k++) begin
         @(negedge fast_in);
         if (fa  < 0 && a_p[0])  fa  = k;
         if (fbb < 0 && b_p[0])  fbb = k;
         if (ff  < 0 && fb_p[0]) ff  = k;
      end
      check("R9 A first edge /8",  fa,  4);
      check("R9 B first edge /8",  fbb, 4);
      check("R9 FB first edge /8", ff,  4);

      master_rst = 1'b1;
      @(negedge fast_in);
      sel_a = 2'd0; sel_fb = 3'd7;                   // /2 and /20
      @(negedge fast_in);
      master_rst = 1'b0;
      fa = -1; ff = -1;
      for (int k = 1; k <= 14; k++) begin
         @(negedge fast_in);
         if (fa < 0 && a_p[0])  fa = k;
         if (ff < 0 && fb_p[0]) ff = k;
      end
      check("R9 A first edge /2",   fa, 1);
      check("R9 FB first edge /20", ff, 10);

      // R10: select change mid-period applies at the next period
      master_rst = 1'b1;
      @(negedge fast_in);
      sel_a = 2'd3;
      @(negedge fast_in);
      master_rst = 1'b0;
      wait_rise(0); t1 = int'($time);
      repeat (2) @(negedge fast_in);
      sel_a = 2'd0;
      wait_rise(0); t2 = int'($time);
      wait_rise(0); t3 = int'($time);
      check("R10 running period kept", t2 - t1, 8 * 20);
      check("R10 next period new",     t3 - t2, 2 * 20);

      // R4: reset asserted mid-run clears at once
      @(negedge fast_in);
      #3 master_rst = 1'b1;
      #1 check_reset_state("mid-run");

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule